// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a synthesizable model of a 128-byte serial EEPROM that answers on a two-wire bus (clock line plus open-drain data line). A fast system clock oversamples both bus lines through synchronizers. The block then detects the bus start and stop conditions and shifts bits in and out on the bus clock edges. It acknowledges every byte it receives and drives read data through an active-high pull-down enable. The host drives the bus clock; the block never holds it low.

No device-select byte is used. The first byte after a start condition carries a 7-bit word address and a direction bit. Write data is gathered in a four-byte page buffer and copied into the storage array only when a stop condition arrives. A busy window of a parameterised number of system clocks follows each copy. During that window the block ignores the bus entirely, so a host can poll with address bytes until one is acknowledged. Reads return the byte at the current address and keep streaming through the whole array for as long as the host acknowledges.

Top module: `twi_eeprom_target`

## Requirements
- R1: After reset the pull-down enable is low, and every one of the 128 storage bytes reads back as 0x00.
- R2: A start condition is the data line falling while the clock line is high, and a stop condition is the data line rising while the clock is high. The first byte after a start is sent MSB first: seven word-address bits, then a direction bit (0 = write, 1 = read).
- R3: The block holds the data line low through the ninth clock after each address byte and each write-data byte it receives. It turns its pull-down on only while the clock line is low.
- R4: Write data bytes followed by a stop condition are stored at the addressed location and can be read back afterwards.
- R5: During a write only the two low address bits advance after each data byte, so the five upper bits stay fixed. A fifth or later byte wraps to the first byte of the same 4-byte page and overwrites it.
- R6: A read sends the byte at the current address MSB first, one bit per clock, with each bit changed only after a falling clock edge.
- R7: While the host acknowledges, a read advances the full 7-bit address after each byte and wraps from 127 to 0.
- R8: When the host does not acknowledge a read byte, the block releases the data line and drives nothing until the next start condition.
- R9: From the stop that commits write data, the block ignores the bus for BUSY_CYCLES system clocks and acknowledges nothing. After that window it acknowledges address bytes again.
- R10: A start condition that arrives before a stop discards the buffered write data. No bytes are stored and no busy window follows.
- R11: A stop that follows an address byte with no complete data byte stores nothing and starts no busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired value) |
| sda_oe | output | 1 | High pulls the data line low; low releases it |

## Verification
The bench targets the corner cases of page wrap and address wrap. It writes six bytes into one page; a design that carried into the upper address bits would spill into the next page instead of overwriting the first two bytes. It starts a read at 126; a design that saturated or stopped at the array end would repeat the last byte rather than wrap to 0. It polls right after a commit and again after the window: one that never went busy would acknowledge the first poll, and one that never came out of busy would never acknowledge. A repeated start after one data byte checks that the staged byte is dropped: a design that committed early would return that byte and go busy. An extra clock after a host non-acknowledge catches a design that keeps driving data.

// File: rtl/twi_ee_pkg.sv
package twi_ee_pkg;

    localparam int unsigned EE_ADDR_W     = 7;
    localparam int unsigned EE_DATA_W     = 8;
    localparam int unsigned EE_PAGE_W     = 2;
    localparam int unsigned EE_WORDS      = 1 << EE_ADDR_W;
    localparam int unsigned EE_PAGE_BYTES = 1 << EE_PAGE_W;
    localparam int unsigned EE_ROW_W      = EE_ADDR_W - EE_PAGE_W;
    localparam int unsigned EE_BIT_W      = $clog2(EE_DATA_W);

    typedef logic [EE_ADDR_W-1:0] ee_addr_t;
    typedef logic [EE_DATA_W-1:0] ee_byte_t;
    typedef logic [EE_ROW_W-1:0]  ee_row_t;
    typedef logic [EE_PAGE_W-1:0] ee_slot_t;
    typedef logic [EE_BIT_W-1:0]  ee_bit_t;
    typedef logic [EE_PAGE_BYTES-1:0][EE_DATA_W-1:0] ee_page_t;
    typedef logic [EE_PAGE_BYTES-1:0] ee_mask_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_TX_LOAD,
        ST_TX,
        ST_HOST_ACK,
        ST_BUSY
    } ee_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } ee_bus_evt_t;

    function automatic ee_row_t ee_row_of(input ee_addr_t a);
        return a[EE_ADDR_W-1:EE_PAGE_W];
    endfunction

    function automatic ee_slot_t ee_slot_of(input ee_addr_t a);
        return a[EE_PAGE_W-1:0];
    endfunction

    // advance inside the page only
    function automatic ee_addr_t ee_page_step(input ee_addr_t a);
        ee_slot_t s;
        s = ee_slot_of(a) + ee_slot_t'(1);
        return {ee_row_of(a), s};
    endfunction

    // advance across the whole array, wrapping at the top
    function automatic ee_addr_t ee_seq_step(input ee_addr_t a);
        return a + ee_addr_t'(1);
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events
    import twi_ee_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_s,
    input  logic        sda_s,
    output ee_bus_evt_t evt
);
    logic scl_p;
    logic sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    always_comb begin
        evt.scl      = scl_s;
        evt.sda      = sda_s;
        evt.scl_rise = scl_s & ~scl_p;
        evt.scl_fall = ~scl_s & scl_p;
        evt.start    = scl_s & scl_p & sda_p & ~sda_s;
        evt.stop     = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/ee_page_stage.sv
module ee_page_stage
    import twi_ee_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     open_row,
    input  ee_row_t  row_in,
    input  logic     put,
    input  ee_slot_t slot,
    input  ee_byte_t byte_in,
    output ee_row_t  row,
    output ee_page_t page,
    output ee_mask_t valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            row   <= '0;
            page  <= '0;
            valid <= '0;
        end else begin
            if (open_row) row <= row_in;
            if (clr) begin
                valid <= '0;
            end else if (put) begin
                page[slot]  <= byte_in;
                valid[slot] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ee_store.sv
module ee_store
    import twi_ee_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     commit,
    input  ee_row_t  row,
    input  ee_page_t page,
    input  ee_mask_t valid,
    input  ee_addr_t rd_addr,
    output ee_byte_t rd_data
);
    ee_byte_t mem [EE_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < EE_WORDS; i++) mem[i] <= '0;
        end else if (commit) begin
            for (int i = 0; i < EE_WORDS; i++) begin
                if (row == ee_row_of(ee_addr_t'(i)) && valid[ee_slot_of(ee_addr_t'(i))])
                    mem[i] <= page[ee_slot_of(ee_addr_t'(i))];
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/twi_eeprom_target.sv
module twi_eeprom_target
    import twi_ee_pkg::*;
#(
    parameter int unsigned BUSY_CYCLES = 2000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int unsigned BCW = $clog2(BUSY_CYCLES + 1);

    logic        scl_s, sda_s, scl_lvl;
    ee_bus_evt_t evt;
    ee_state_e   st;
    ee_bit_t     bitcnt;
    ee_byte_t    shreg;
    ee_addr_t    addr;
    logic        rw;
    logic        ack_on;
    logic [BCW-1:0] busy_cnt;

    logic      stg_clr, stg_open, stg_put, commit;
    ee_row_t   stg_row;
    ee_page_t  stg_page;
    ee_mask_t  stg_valid;
    ee_byte_t  rd_data;
    ee_byte_t  rx_byte;
    logic      byte_done;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (.clk(clk), .rst(rst), .din(scl_i), .dout(scl_s));
    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (.clk(clk), .rst(rst), .din(sda_i), .dout(sda_s));

    twi_bus_events u_evt (.clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s), .evt(evt));

    assign scl_lvl   = evt.scl;
    assign rx_byte   = {shreg[EE_DATA_W-2:0], evt.sda};
    assign byte_done = evt.scl_rise && (bitcnt == ee_bit_t'(EE_DATA_W - 1));

    // page buffer control
    assign commit   = (st != ST_BUSY) && evt.stop && (|stg_valid);
    assign stg_clr  = ((st != ST_BUSY) && evt.start) || commit;
    assign stg_open = (st == ST_ADDR) && byte_done;
    assign stg_put  = (st == ST_WDATA) && byte_done && !evt.start && !evt.stop;

    ee_page_stage u_stage (
        .clk(clk), .rst(rst),
        .clr(stg_clr),
        .open_row(stg_open),
        .row_in(ee_row_of(rx_byte[EE_DATA_W-1:1])),
        .put(stg_put),
        .slot(ee_slot_of(addr)),
        .byte_in(rx_byte),
        .row(stg_row),
        .page(stg_page),
        .valid(stg_valid)
    );

    ee_store u_store (
        .clk(clk), .rst(rst),
        .commit(commit),
        .row(stg_row),
        .page(stg_page),
        .valid(stg_valid),
        .rd_addr(addr),
        .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            addr     <= '0;
            rw       <= 1'b0;
            ack_on   <= 1'b0;
            sda_oe   <= 1'b0;
            busy_cnt <= '0;
        end else if (st == ST_BUSY) begin
            sda_oe <= 1'b0;
            if (busy_cnt == BCW'(BUSY_CYCLES - 1)) begin
                st       <= ST_IDLE;
                busy_cnt <= '0;
            end else begin
                busy_cnt <= busy_cnt + BCW'(1);
            end
        end else if (evt.start) begin
            st     <= ST_ADDR;
            bitcnt <= '0;
            ack_on <= 1'b0;
            sda_oe <= 1'b0;
        end else if (evt.stop) begin
            sda_oe   <= 1'b0;
            ack_on   <= 1'b0;
            busy_cnt <= '0;
            st       <= commit ? ST_BUSY : ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (evt.scl_rise) begin
                        shreg <= rx_byte;
                        if (byte_done) begin
                            addr   <= shreg[EE_ADDR_W-1:0];
                            rw     <= evt.sda;
                            ack_on <= 1'b0;
                            st     <= ST_ADDR_ACK;
                        end else begin
                            bitcnt <= bitcnt + ee_bit_t'(1);
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (evt.scl_fall) begin
                        if (!ack_on) begin
                            ack_on <= 1'b1;
                            sda_oe <= 1'b1;
                        end else begin
                            ack_on <= 1'b0;
                            bitcnt <= '0;
                            if (rw) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[EE_DATA_W-1];
                                st     <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= ST_WDATA;
                            end
                        end
                    end
                end
                ST_WDATA: begin
                    if (evt.scl_rise) begin
                        shreg <= rx_byte;
                        if (byte_done) begin
                            addr   <= ee_page_step(addr);
                            ack_on <= 1'b0;
                            st     <= ST_WDATA_ACK;
                        end else begin
                            bitcnt <= bitcnt + ee_bit_t'(1);
                        end
                    end
                end
                ST_WDATA_ACK: begin
                    if (evt.scl_fall) begin
                        if (!ack_on) begin
                            ack_on <= 1'b1;
                            sda_oe <= 1'b1;
                        end else begin
                            ack_on <= 1'b0;
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            st     <= ST_WDATA;
                        end
                    end
                end
                ST_TX: begin
                    if (evt.scl_fall) begin
                        if (bitcnt == ee_bit_t'(EE_DATA_W - 1)) begin
                            sda_oe <= 1'b0;
                            st     <= ST_HOST_ACK;
                        end else begin
                            shreg  <= {shreg[EE_DATA_W-2:0], 1'b0};
                            sda_oe <= ~shreg[EE_DATA_W-2];
                            bitcnt <= bitcnt + ee_bit_t'(1);
                        end
                    end
                end
                ST_HOST_ACK: begin
                    if (evt.scl_rise) begin
                        if (!evt.sda) begin
                            addr <= ee_seq_step(addr);
                            st   <= ST_TX_LOAD;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                ST_TX_LOAD: begin
                    if (evt.scl_fall) begin
                        shreg  <= rd_data;
                        sda_oe <= ~rd_data[EE_DATA_W-1];
                        bitcnt <= '0;
                        st     <= ST_TX;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/twi_ee_checker.sv
module twi_ee_checker
    import twi_ee_pkg::*;
#(
    parameter int unsigned BUSY_CYCLES = 2000,
    parameter int unsigned BCW = 11
) (
    input logic           clk,
    input logic           rst,
    input logic           scl_lvl,
    input logic           sda_oe,
    input ee_state_e      st,
    input logic [BCW-1:0] busy_cnt,
    input logic           commit,
    input ee_row_t        row
);
    logic in_write;
    assign in_write = (st == ST_WDATA) || (st == ST_WDATA_ACK);

    // R3: pull-down only switches on while the clock line is low
    a_r3_drive_on_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_lvl);

    // R9: silent while busy
    a_r9_busy_silent: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BUSY) |-> !sda_oe);

    // R9: busy counter stays inside its window
    a_r9_busy_bound: assert property (@(posedge clk) disable iff (rst)
        busy_cnt < BCW'(BUSY_CYCLES));

    // R4: a commit always opens the busy window
    a_r4_commit_busy: assert property (@(posedge clk) disable iff (rst)
        commit |=> (st == ST_BUSY));

    // R5: page row is held while a write is in progress
    a_r5_row_fixed: assert property (@(posedge clk) disable iff (rst)
        (in_write && $past(in_write)) |-> $stable(row));

    // R8: line released while waiting for the host acknowledge
    a_r8_release_host_ack: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOST_ACK) |-> !sda_oe);
endmodule

bind twi_eeprom_target twi_ee_checker #(.BUSY_CYCLES(BUSY_CYCLES), .BCW(BCW)) u_chk (
    .clk(clk),
    .rst(rst),
    .scl_lvl(scl_lvl),
    .sda_oe(sda_oe),
    .st(st),
    .busy_cnt(busy_cnt),
    .commit(commit),
    .row(stg_row)
);

// File: tb/tb_twi_eeprom_target.sv
module tb_twi_eeprom_target;
    localparam int BUSY = 300;
    localparam int H    = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic sda_oe;
    logic sda_line;

    assign sda_line = sda_h & ~sda_oe;

    always #5 clk = ~clk;

    twi_eeprom_target #(.BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .scl_i(scl_h), .sda_i(sda_line), .sda_oe(sda_oe)
    );

    int errs = 0;
    int checks = 0;
    logic [7:0] model [128];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] pat(input int a, input int salt);
        return 8'(((a * 29) + (salt * 7) + 3) ^ 8'h5A);
    endfunction

    task automatic bus_start();
        sda_h = 1'b1; tick(H/2);
        scl_h = 1'b1; tick(H/2);
        sda_h = 1'b0; tick(H/2);
        scl_h = 1'b0; tick(H/2);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; tick(H/2);
        scl_h = 1'b1; tick(H/2);
        sda_h = 1'b1; tick(H);
    endtask

    task automatic send_bit(input logic b);
        sda_h = b; tick(H/2);
        scl_h = 1'b1; tick(H);
        scl_h = 1'b0; tick(H/2);
    endtask

    task automatic get_bit(output logic b);
        sda_h = 1'b1; tick(H/2);
        scl_h = 1'b1; tick(H/2);
        b = sda_line; tick(H/2);
        scl_h = 1'b0; tick(H/2);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        get_bit(a);
        ack = !a;
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        send_bit(!ack);
    endtask

    task automatic write_txn(input int addr, input int n, input int salt);
        bit ack;
        bus_start();
        send_byte({7'(addr), 1'b0}, ack);
        chk(ack, "R2/R3 address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(pat(addr + k, salt), ack);
            chk(ack, "R3 data ack", ack, 1);
        end
        bus_stop();
        for (int k = 0; k < n; k++)
            model[(addr & 7'h7C) | ((addr + k) & 3)] = pat(addr + k, salt);
    endtask

    task automatic wait_ready();
        bit ack = 1'b0;
        for (int t = 0; t < 20 && !ack; t++) begin
            bus_start();
            send_byte(8'h00, ack);
            bus_stop();
        end
        chk(ack, "R9 ready after window", ack, 1);
    endtask

    task automatic read_check(input int addr, input int n, input string req);
        bit ack;
        logic [7:0] v;
        bus_start();
        send_byte({7'(addr), 1'b1}, ack);
        chk(ack, "R2/R3 read address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(v, k != n - 1);
            chk(v == model[(addr + k) % 128], req, v, model[(addr + k) % 128]);
        end
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        bit ack;
        logic b;
        logic [7:0] v;
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        tick(5);
        rst = 1'b0;
        tick(5);

        // R1: reset state
        chk(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);
        read_check(8'h33, 1, "R1 cleared byte");

        // R4 / R9: byte write, immediate poll, then ready
        write_txn(5, 1, 1);
        bus_start();
        send_byte({7'd5, 1'b0}, ack);
        chk(!ack, "R9 no ack while busy", ack, 0);
        bus_stop();
        tick(BUSY + 20);
        bus_start();
        send_byte({7'd5, 1'b0}, ack);
        chk(ack, "R9 ack after window", ack, 1);
        bus_stop();
        // R11: address-only write leaves block ready
        bus_start();
        send_byte({7'd5, 1'b0}, ack);
        chk(ack, "R11 no busy without data", ack, 1);
        bus_stop();
        read_check(5, 1, "R4/R6 byte write readback");

        // R5: four bytes starting mid-page
        write_txn(9, 4, 2);
        wait_ready();
        read_check(8, 4, "R5 page wrap order");

        // R5: six bytes overwrite the page start
        write_txn(16, 6, 3);
        wait_ready();
        read_check(16, 5, "R5 overwrite and next page untouched");

        // R10: repeated start drops staged data
        bus_start();
        send_byte({7'h20, 1'b0}, ack);
        send_byte(8'h55, ack);
        bus_start();
        send_byte({7'h20, 1'b1}, ack);
        chk(ack, "R10 no busy after discard", ack, 1);
        recv_byte(v, 1'b0);
        chk(v == model[8'h20], "R10 staged byte discarded", v, model[8'h20]);
        bus_stop();

        // R7: address wrap at the top
        write_txn(126, 2, 4);
        wait_ready();
        read_check(126, 4, "R7 wrap 127 to 0");

        // R8: after a host nack the line stays released
        bus_start();
        send_byte({7'h40, 1'b1}, ack);
        recv_byte(v, 1'b0);
        get_bit(b);
        chk(b == 1'b1, "R8 line released after nack", b, 1);
        chk(sda_oe == 1'b0, "R8 oe low after nack", sda_oe, 0);
        bus_stop();

        // R6/R7: fill whole array, then stream past the end
        for (int p = 0; p < 32; p++) begin
            write_txn(p * 4, 4, 5 + p);
            wait_ready();
        end
        read_check(0, 130, "R6/R7 full sweep");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule